// File: doc/BRIEF.md
# Burst Column Order Generator

This block turns one column command into the list of column addresses that a double-data-rate burst touches. A one-cycle start pulse supplies the first column and a 4-bit mode field. The burst length is two, four or eight beats, and the field also picks one of two beat orders. Two beats move in every clock cycle, one on each clock edge. The block therefore presents a pair of column addresses per cycle until the burst is complete.

In sequential order the low address bits count upward from the start column and wrap around inside the aligned window of burst-length columns. In interleaved order each beat index is XOR-ed into the start column. In both orders the column bits above the window never change. A controller data path or a memory model uses the outputs to steer each data word. An abort input ends a burst early. A start pulse that arrives while a burst is running replaces that burst.

Top module: `burst_col_order`

## Requirements
- R1: The length code `mode[2:0]` selects the burst length: 1 gives 2 beats, 2 gives 4 beats, 3 gives 8 beats. A burst occupies length/2 consecutive cycles with `beat_valid` high.
- R2: `mode[3]` selects the beat order: 0 is sequential and 1 is interleaved.
- R3: In interleaved order, beat i carries the column `start_col XOR i`.
- R4: In sequential order, the low log2(length) bits of beat i equal (start_col + i) modulo the burst length.
- R5: Column bits at and above bit log2(length) equal the start column on every beat.
- R6: Lane 0 (`beat_col[COL_W-1:0]`) carries beat 2k and lane 1 carries beat 2k+1. The first pair appears in the cycle after the start pulse is sampled.
- R7: `last_beat` is high exactly in the cycle that carries beat length-1, and `beat_valid` is low in the following cycle unless a new start is sampled.
- R8: A start with length code 0, 4, 5, 6 or 7 raises `mode_err` for one cycle after it is sampled. It produces no beats and cancels any burst in progress.
- R9: `abort` sampled during a burst makes `beat_valid` low from the next cycle. `abort` has no effect while idle.
- R10: A start sampled during a burst, including one sampled together with `abort`, restarts at beat 0 of the new burst in the next cycle. Start has priority over abort.
- R11: During and after reset, `beat_valid`, `last_beat` and `mode_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle burst start pulse |
| start_col | input | COL_W | First column of the burst |
| mode | input | 4 | [2:0] length code, [3] order select |
| abort | input | 1 | Stop the running burst |
| beat_col | output | 2*COL_W | Column pair for this cycle, lane 0 in the low bits |
| beat_valid | output | 1 | Column pair is valid |
| last_beat | output | 1 | This pair contains the final beat |
| mode_err | output | 1 | The previous start had a reserved length code |

## Verification
The functions that can fall in the same cycle are a burst ending and a new start, and `abort` together with `start`. The bench provokes the first case by pulsing start in the cycle that carries `last_beat`. It provokes the second by raising both inputs in the middle of an eight-beat burst. In both cases the next cycle must show beat 0 and beat 1 of the new burst, with `last_beat` low. A reserved-code start issued mid-burst is also checked: the running burst must stop and `mode_err` must pulse in the same cycle.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
   typedef enum logic {
      ORD_SEQ   = 1'b0,
      ORD_INTLV = 1'b1
   } burst_order_e;

   localparam int MODE_W = 4;
endpackage

// File: rtl/burst_mode_decode.sv
module burst_mode_decode
   import burst_col_pkg::*;
#(
   parameter int MAXLG = 3
) (
   input  logic [MODE_W-1:0] mode,
   output logic [2:0]        lg,
   output burst_order_e      ord,
   output logic              legal
);
   always_comb begin
      lg    = mode[2:0];
      ord   = burst_order_e'(mode[3]);
      legal = (mode[2:0] >= 3'd1) && (int'(mode[2:0]) <= MAXLG);
   end
endmodule

// File: rtl/burst_beat_addr.sv
module burst_beat_addr
   import burst_col_pkg::*;
#(
   parameter int COL_W = 10,
   parameter int MAXLG = 3
) (
   input  logic [COL_W-1:0] base,
   input  logic [MAXLG-1:0] beat,
   input  logic [2:0]       lg,
   input  burst_order_e     ord,
   output logic [COL_W-1:0] col
);
   logic [COL_W-1:0] win_mask;
   logic [COL_W-1:0] beat_ext;
   logic [COL_W-1:0] seq_col;
   logic [COL_W-1:0] ilv_col;

   always_comb begin
      for (int b = 0; b < COL_W; b++) begin
         win_mask[b] = (b < int'(lg));
      end
      beat_ext = COL_W'(beat);
      seq_col  = (base & ~win_mask) | ((base + beat_ext) & win_mask);
      ilv_col  = base ^ beat_ext;
      col      = (ord == ORD_INTLV) ? ilv_col : seq_col;
   end
endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl #(
   parameter int MAXLG = 3,
   parameter int BPC   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             legal,
   input  logic             abort,
   input  logic [2:0]       lg_q,
   output logic             active,
   output logic [MAXLG-1:0] beat_idx,
   output logic             last,
   output logic             err
);
   localparam int CW = MAXLG + 1;

   logic [CW-1:0] burst_len;
   logic [CW-1:0] next_idx;

   always_comb begin
      burst_len = CW'(1) << lg_q;
      next_idx  = {1'b0, beat_idx} + CW'(BPC);
      last      = active && (next_idx == burst_len);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         beat_idx <= '0;
         err      <= 1'b0;
      end else begin
         err <= start && !legal;
         if (start) begin
            active   <= legal;
            beat_idx <= '0;
         end else if (active && (abort || last)) begin
            active <= 1'b0;
         end else if (active) begin
            beat_idx <= next_idx[MAXLG-1:0];
         end
      end
   end
endmodule

// File: rtl/burst_col_order.sv
module burst_col_order
   import burst_col_pkg::*;
#(
   parameter int COL_W = 10,
   parameter int MAXLG = 3,
   parameter int BPC   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [COL_W-1:0]     start_col,
   input  logic [3:0]           mode,
   input  logic                 abort,
   output logic [BPC*COL_W-1:0] beat_col,
   output logic                 beat_valid,
   output logic                 last_beat,
   output logic                 mode_err
);
   localparam int MIN_LEN = 2;

   generate
      if (MAXLG < 1 || MAXLG > 7)
         $error("MAXLG must lie in 1..7");
      if (MAXLG >= COL_W)
         $error("burst window must be narrower than the column");
      if (BPC != 1 && BPC != MIN_LEN)
         $error("BPC must be 1 or 2");
   endgenerate

   logic [2:0]       dec_lg;
   burst_order_e     dec_ord;
   logic             dec_legal;
   logic [COL_W-1:0] base_q;
   logic [2:0]       lg_q;
   burst_order_e     ord_q;
   logic [MAXLG-1:0] beat_idx;

   burst_mode_decode #(.MAXLG(MAXLG)) u_dec (
      .mode  (mode),
      .lg    (dec_lg),
      .ord   (dec_ord),
      .legal (dec_legal)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         lg_q   <= 3'd1;
         ord_q  <= ORD_SEQ;
      end else if (start && dec_legal) begin
         base_q <= start_col;
         lg_q   <= dec_lg;
         ord_q  <= dec_ord;
      end
   end

   burst_seq_ctrl #(.MAXLG(MAXLG), .BPC(BPC)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .legal    (dec_legal),
      .abort    (abort),
      .lg_q     (lg_q),
      .active   (beat_valid),
      .beat_idx (beat_idx),
      .last     (last_beat),
      .err      (mode_err)
   );

   generate
      for (genvar ln = 0; ln < BPC; ln++) begin : g_lane
         logic [MAXLG-1:0] lane_beat;
         assign lane_beat = beat_idx + MAXLG'(ln);
         burst_beat_addr #(.COL_W(COL_W), .MAXLG(MAXLG)) u_addr (
            .base (base_q),
            .beat (lane_beat),
            .lg   (lg_q),
            .ord  (ord_q),
            .col  (beat_col[ln*COL_W +: COL_W])
         );
      end
   endgenerate
endmodule

// File: rtl/burst_col_order_chk.sv
module burst_col_order_chk #(
   parameter int COL_W = 10,
   parameter int MAXLG = 3,
   parameter int BPC   = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 start,
   input logic [3:0]           mode,
   input logic                 abort,
   input logic [BPC*COL_W-1:0] beat_col,
   input logic                 beat_valid,
   input logic                 last_beat,
   input logic                 mode_err
);
   logic good_code;
   assign good_code = (mode[2:0] != 3'd0) && (int'(mode[2:0]) <= MAXLG);

   // R7
   last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_beat |-> beat_valid);

   // R7
   done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_beat && !start |=> !beat_valid);

   // R8
   err_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |-> !beat_valid);

   // R8
   bad_code_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && !good_code |=> mode_err && !beat_valid);

   // R9
   abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid && abort && !start |=> !beat_valid);

   // R10
   start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && good_code |=> beat_valid && !mode_err);

   // R5
   upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid && $past(beat_valid) && !$past(start)
      |-> $stable(beat_col[COL_W-1:MAXLG]));

   generate
      if (BPC == 2) begin : g_pair
         // R6
         lanes_differ_chk: assert property (@(posedge clk) disable iff (!rst_n)
            beat_valid |-> beat_col[COL_W-1:0] != beat_col[2*COL_W-1:COL_W]);
      end
   endgenerate
endmodule

bind burst_col_order burst_col_order_chk #(.COL_W(COL_W), .MAXLG(MAXLG), .BPC(BPC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .mode       (mode),
   .abort      (abort),
   .beat_col   (beat_col),
   .beat_valid (beat_valid),
   .last_beat  (last_beat),
   .mode_err   (mode_err)
);

// File: tb/sim_burst_col_order.sv
`timescale 1ns/1ps
module sim_burst_col_order;
   localparam int COL_W = 10;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start = 1'b0;
   logic [COL_W-1:0]   start_col = '0;
   logic [3:0]         mode = 4'd0;
   logic               abort = 1'b0;
   logic [2*COL_W-1:0] beat_col;
   logic               beat_valid, last_beat, mode_err;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   burst_col_order #(.COL_W(COL_W), .MAXLG(3), .BPC(2)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
      .mode(mode), .abort(abort), .beat_col(beat_col),
      .beat_valid(beat_valid), .last_beat(last_beat), .mode_err(mode_err)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] c, input int lg, input bit ilv, input int i);
      logic [COL_W-1:0] m;
      m = COL_W'((1 << lg) - 1);
      if (ilv) return c ^ COL_W'(i);
      return (c & ~m) | ((c + COL_W'(i)) & m);
   endfunction

   // pulse start at negedge; return at the negedge where pair 0 is visible
   task automatic kick(input logic [COL_W-1:0] c, input logic [3:0] md, input bit ab);
      start = 1'b1; start_col = c; mode = md; abort = ab;
      @(negedge clk);
      start = 1'b0; abort = 1'b0;
   endtask

   task automatic check_pair(input logic [COL_W-1:0] c, input int lg, input bit ilv, input int k, input string req);
      int bl;
      bl = 1 << lg;
      chk(beat_valid === 1'b1, "R1 valid", 32'(beat_valid), 1);
      chk(beat_col[COL_W-1:0] === exp_col(c, lg, ilv, 2*k), req,
          32'(beat_col[COL_W-1:0]), 32'(exp_col(c, lg, ilv, 2*k)));
      chk(beat_col[2*COL_W-1:COL_W] === exp_col(c, lg, ilv, 2*k+1), req,
          32'(beat_col[2*COL_W-1:COL_W]), 32'(exp_col(c, lg, ilv, 2*k+1)));
      chk(last_beat === (2*k+1 == bl-1), "R7 last", 32'(last_beat), 32'(2*k+1 == bl-1));
   endtask

   initial begin : watchdog
      #(200000 * 5);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(beat_valid === 1'b0 && last_beat === 1'b0 && mode_err === 1'b0,
          "R11 reset", {29'd0, beat_valid, last_beat, mode_err}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(beat_valid === 1'b0, "R11 idle", 32'(beat_valid), 0);

      // Sweep: R1 R2 R3 R4 R5 R6 R7
      for (int lg = 1; lg <= 3; lg++) begin
         for (int o = 0; o < 2; o++) begin
            for (int s = 0; s < 16; s++) begin
               logic [COL_W-1:0] c;
               c = COL_W'(s * 73 + 640);
               kick(c, {o[0], 3'(lg)}, 1'b0);
               for (int k = 0; k < (1 << lg) / 2; k++) begin
                  check_pair(c, lg, o[0], k, o[0] ? "R3 R5 R6 interleaved" : "R4 R5 R6 sequential");
                  @(negedge clk);
               end
               chk(beat_valid === 1'b0, "R7 ends", 32'(beat_valid), 0);
            end
         end
      end

      // R9 abort mid burst
      kick(10'h2a5, 4'b0011, 1'b0);
      check_pair(10'h2a5, 3, 1'b0, 0, "R6 before abort");
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      chk(beat_valid === 1'b0, "R9 abort stops", 32'(beat_valid), 0);
      // R9 abort while idle has no effect
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      chk(beat_valid === 1'b0 && mode_err === 1'b0, "R9 idle abort", 32'(beat_valid), 0);
      kick(10'h133, 4'b1010, 1'b0);
      check_pair(10'h133, 2, 1'b1, 0, "R9 start after idle abort");

      // R10 start together with abort mid burst
      kick(10'h0f1, 4'b0011, 1'b0);
      @(negedge clk);
      kick(10'h3c6, 4'b1011, 1'b1);
      check_pair(10'h3c6, 3, 1'b1, 0, "R10 start beats abort");
      @(negedge clk);
      check_pair(10'h3c6, 3, 1'b1, 1, "R10 continues");

      // R10 start in the last cycle of a burst
      kick(10'h055, 4'b0001, 1'b0);
      chk(last_beat === 1'b1, "R7 last of 2", 32'(last_beat), 1);
      kick(10'h1e9, 4'b0011, 1'b0);
      check_pair(10'h1e9, 3, 1'b0, 0, "R10 back to back");

      // R8 reserved code mid burst
      @(negedge clk);
      kick(10'h111, 4'b0000, 1'b0);
      chk(mode_err === 1'b1, "R8 err pulse", 32'(mode_err), 1);
      chk(beat_valid === 1'b0, "R8 cancels", 32'(beat_valid), 0);
      @(negedge clk);
      chk(mode_err === 1'b0 && beat_valid === 1'b0, "R8 one cycle", 32'(mode_err), 0);
      for (int r = 4; r < 8; r++) begin
         kick(10'h222, {1'b1, 3'(r)}, 1'b0);
         chk(mode_err === 1'b1 && beat_valid === 1'b0, "R8 reserved code", {30'd0, mode_err, beat_valid}, 2);
         @(negedge clk);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule